// File: doc/BRIEF.md
# Speculation Tag Allocator with Wrong-Path Kill

This block labels in-flight instructions with speculation tags so that wrong-path work can be removed after a branch misprediction. It owns a pool of `NTAGS` tag values and an age-ordered list of the tags that are live. The youngest live tag is the current tag. Every instruction accepted at dispatch is stamped with it. A predicted branch that is accepted also opens a fresh tag from the pool, and that tag becomes current for the instructions behind it. Tag values say nothing about age. Program order is kept only by the list.

When a branch resolves, its client names the tag the branch opened. On a correct prediction that tag goes back to the pool and leaves the list. The client must issue that release only once nothing that still carries the tag is in flight. On a misprediction, the named tag and every tag opened after it are broadcast on the kill port, one tag per cycle, youngest first. Each tag is returned to the pool as it is broadcast. Dispatch is held until the last of them has gone out. After that, the tag the branch itself carried is current again. Holders of instructions compare their tag against the kill broadcast and drop matches.

Top module: `btag_alloc`

## Requirements
- R1: After reset only tag 0 is live, `disp_tag` is 0, `kill_valid` is low, and a branch can be accepted (`disp_ready` high with `disp_is_br` high).
- R2: An accepted non-branch dispatch receives `disp_tag` and leaves the current tag unchanged.
- R3: An accepted branch receives `disp_tag`, opens the tag shown on `disp_new_tag`, and that tag is `disp_tag` from the next cycle.
- R4: The tag opened is always the lowest-numbered free tag, tags being the numbers 0 to `NTAGS`-1.
- R5: With all `NTAGS` tags live, `disp_ready` is low for a branch and high for a non-branch, and a refused branch changes nothing.
- R6: A correct resolve frees the named tag and removes it from the age order. If it was the youngest, the current tag falls back to the next older live tag in allocation order, not in numeric order.
- R7: A mispredict naming tag T broadcasts on `kill_tag`, from the next cycle, one tag per cycle, every live tag from the youngest down to and including T.
- R8: `disp_ready` is low in every broadcast cycle and high again in the cycle after the last one.
- R9: After the broadcasts end, `disp_tag` is the live tag that was immediately older than T.
- R10: A resolve is ignored when it names a tag that is not live, when it names the oldest live tag, or when it arrives while a broadcast is in progress.
- R11: A branch accepted in the same cycle as a resolve is ordered after it. Under a mispredict its new tag is broadcast first. Under a correct resolve its new tag becomes current.
- R12: Tags that have been freed, whether by release or by kill, are handed out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_is_br | input | 1 | The offered instruction is a predicted branch |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | TW | Current tag, stamped on the accepted instruction |
| disp_new_tag | output | TW | Tag a branch accepted this cycle opens |
| res_valid | input | 1 | A branch resolves this cycle |
| res_tag | input | TW | Tag the resolving branch opened |
| res_mispred | input | 1 | The resolving branch was mispredicted |
| kill_valid | output | 1 | A tag is being invalidated this cycle |
| kill_tag | output | TW | Tag being invalidated |

## Verification
The collision that matters is a branch dispatch accepted in the same cycle as a resolve. Dispatch is not gated by the resolve input, so both operations land on the age list at the same clock edge. The bench drives both in one cycle. Under a mispredict, it expects the branch's freshly opened tag to be the first tag killed, followed by the named tag, with the pre-branch tag current afterwards. Under a correct release of the youngest tag, it expects the new tag to end up current, and the released tag's predecessor to surface once the new tag is released in turn.

// File: rtl/btag_pkg.sv
`timescale 1ns/1ps
package btag_pkg;

  typedef enum logic {
    KM_RUN  = 1'b0,
    KM_KILL = 1'b1
  } kill_mode_e;

endpackage

// File: rtl/btag_pool.sv
`timescale 1ns/1ps
module btag_pool #(
  parameter int NTAGS = 4,
  parameter int TW    = $clog2(NTAGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  input  logic [TW-1:0] give_tag,
  output logic          any_free,
  output logic [TW-1:0] pick_tag
);

  logic [NTAGS-1:0] free_q;

  // lowest set bit wins
  function automatic logic [TW-1:0] first_set(input logic [NTAGS-1:0] v);
    logic [TW-1:0] r;
    r = '0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (v[i]) r = TW'(i);
    end
    return r;
  endfunction

  assign any_free = |free_q;
  assign pick_tag = first_set(free_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= {{(NTAGS-1){1'b1}}, 1'b0};
    end else begin
      if (take) free_q[pick_tag] <= 1'b0;
      if (give) free_q[give_tag] <= 1'b1;
    end
  end

  p_take_needs_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> any_free);

  p_give_in_use_r12: assert property (@(posedge clk) disable iff (!rst_n)
    give |-> !free_q[give_tag]);

  p_take_give_apart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && give) |-> (pick_tag != give_tag));

endmodule

// File: rtl/btag_order.sv
`timescale 1ns/1ps
module btag_order #(
  parameter int NTAGS = 4,
  parameter int TW    = $clog2(NTAGS),
  parameter int CW    = $clog2(NTAGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          drop,
  input  logic [TW-1:0] drop_idx,
  input  logic          pop,
  input  logic [TW-1:0] query_tag,
  output logic [TW-1:0] tail_tag,
  output logic [CW-1:0] cnt,
  output logic          hit,
  output logic [TW-1:0] hit_idx
);

  logic [TW-1:0] ent_q [NTAGS];
  logic [TW-1:0] ent_d [NTAGS];
  logic [CW-1:0] cnt_q, cnt_d;

  assign cnt      = cnt_q;
  assign tail_tag = ent_q[TW'(cnt_q - CW'(1))];

  // position lookup among live entries
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NTAGS; i++) begin
      if (CW'(i) < cnt_q && ent_q[i] == query_tag) begin
        hit     = 1'b1;
        hit_idx = TW'(i);
      end
    end
  end

  // removal first, then append: a same-cycle branch is younger
  always_comb begin
    ent_d = ent_q;
    cnt_d = cnt_q;
    if (drop) begin
      for (int i = 0; i < NTAGS - 1; i++) begin
        if (i >= int'(drop_idx)) ent_d[i] = ent_q[i+1];
      end
      cnt_d = cnt_d - CW'(1);
    end
    if (pop) cnt_d = cnt_d - CW'(1);
    if (push) begin
      ent_d[cnt_d[TW-1:0]] = push_tag;
      cnt_d = cnt_d + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAGS; i++) ent_q[i] <= '0;
      cnt_q <= CW'(1);
    end else begin
      ent_q <= ent_d;
      cnt_q <= cnt_d;
    end
  end

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CW'(NTAGS)));

  p_push_has_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !drop) |-> (cnt_q < CW'(NTAGS)));

  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !drop) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/btag_kill.sv
`timescale 1ns/1ps
module btag_kill
  import btag_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_len,
  input  logic [CW-1:0] cnt,
  output logic          busy,
  output logic          last
);

  kill_mode_e    mode_q;
  logic [CW-1:0] stop_q;

  assign busy = (mode_q == KM_KILL);
  assign last = busy && ((cnt - CW'(1)) == stop_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= KM_RUN;
      stop_q <= '0;
    end else if (start) begin
      mode_q <= KM_KILL;
      stop_q <= start_len;
    end else if (last) begin
      mode_q <= KM_RUN;
    end
  end

  p_stop_below_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt > stop_q));

  p_start_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

endmodule

// File: rtl/btag_alloc.sv
`timescale 1ns/1ps
module btag_alloc #(
  parameter int NTAGS = 4,
  parameter int TW    = $clog2(NTAGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic          disp_is_br,
  output logic          disp_ready,
  output logic [TW-1:0] disp_tag,
  output logic [TW-1:0] disp_new_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic          res_mispred,
  output logic          kill_valid,
  output logic [TW-1:0] kill_tag
);

  localparam int CW = $clog2(NTAGS + 1);

  // named internal events
  logic          any_free, busy, last;
  logic          disp_fire, br_fire;
  logic          res_ok, rel_fire, kill_start;
  logic          pool_give;
  logic [TW-1:0] pick_tag, tail_tag, give_tag, hit_idx;
  logic [CW-1:0] cnt;
  logic          hit;

  assign disp_ready   = !busy && (!disp_is_br || any_free);
  assign disp_fire    = disp_valid && disp_ready;
  assign br_fire      = disp_fire && disp_is_br;
  assign disp_tag     = tail_tag;
  assign disp_new_tag = pick_tag;

  // oldest live tag and resolves during a kill walk are not accepted
  assign res_ok     = res_valid && !busy && hit && (hit_idx != '0);
  assign rel_fire   = res_ok && !res_mispred;
  assign kill_start = res_ok && res_mispred;

  assign pool_give  = rel_fire || busy;
  assign give_tag   = rel_fire ? res_tag : tail_tag;

  assign kill_valid = busy;
  assign kill_tag   = tail_tag;

  btag_pool #(.NTAGS(NTAGS), .TW(TW)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (br_fire),
    .give     (pool_give),
    .give_tag (give_tag),
    .any_free (any_free),
    .pick_tag (pick_tag)
  );

  btag_order #(.NTAGS(NTAGS), .TW(TW), .CW(CW)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (br_fire),
    .push_tag  (pick_tag),
    .drop      (rel_fire),
    .drop_idx  (hit_idx),
    .pop       (busy),
    .query_tag (res_tag),
    .tail_tag  (tail_tag),
    .cnt       (cnt),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  btag_kill #(.CW(CW)) u_kill (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (kill_start),
    .start_len (CW'(hit_idx)),
    .cnt       (cnt),
    .busy      (busy),
    .last      (last)
  );

  p_branch_sets_current_r3: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire |=> (disp_tag == $past(disp_new_tag)));

  p_plain_keeps_current_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && !disp_is_br && !res_valid) |=> (disp_tag == $past(disp_tag)));

  p_kill_follows_mispredict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_start |=> kill_valid);

  p_kill_tags_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_valid && $past(kill_valid)) |-> (kill_tag != $past(kill_tag)));

  p_kill_holds_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_valid |-> !disp_ready);

endmodule

// File: tb/btag_alloc_bench.sv
`timescale 1ns/1ps
module btag_alloc_bench;

  localparam int NT = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          disp_valid, disp_is_br, disp_ready;
  logic [TW-1:0] disp_tag, disp_new_tag;
  logic          res_valid, res_mispred;
  logic [TW-1:0] res_tag;
  logic          kill_valid;
  logic [TW-1:0] kill_tag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  btag_alloc #(.NTAGS(NT), .TW(TW)) u_btag_alloc (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_is_br(disp_is_br), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .disp_new_tag(disp_new_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_mispred(res_mispred),
    .kill_valid(kill_valid), .kill_tag(kill_tag)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 1'b0; disp_is_br = 1'b0;
    res_valid = 1'b0; res_tag = '0; res_mispred = 1'b0;
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic op(input bit dv, input bit br, input bit rv, input int rt,
                    input bit rm, output bit rdy, output int nt);
    disp_valid = dv; disp_is_br = br;
    res_valid = rv; res_tag = TW'(rt); res_mispred = rm;
    #1;
    rdy = disp_ready;
    nt  = int'(disp_new_tag);
    @(negedge clk);
    idle();
  endtask

  task automatic branch(input string req, input int exp_new);
    bit rdy; int nt;
    op(1'b1, 1'b1, 1'b0, 0, 1'b0, rdy, nt);
    check_eq({req, " branch accepted"}, int'(rdy), 1);
    check_eq({req, " opened tag"}, nt, exp_new);
  endtask

  task automatic resolve(input int tag, input bit mis);
    bit rdy; int nt;
    op(1'b0, 1'b0, 1'b1, tag, mis, rdy, nt);
  endtask

  task automatic expect_kill(input string req, input int tag);
    check_eq({req, " kill_valid"}, int'(kill_valid), 1);
    check_eq({req, " kill_tag"}, int'(kill_tag), tag);
    disp_is_br = 1'b1; #1;
    check_eq({req, " dispatch held"}, int'(disp_ready), 0);
    disp_is_br = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_eq("R1 disp_tag", int'(disp_tag), 0);
    check_eq("R1 kill_valid", int'(kill_valid), 0);
    disp_is_br = 1'b1; #1;
    check_eq("R1 branch ready", int'(disp_ready), 1);
    check_eq("R4 first opened tag", int'(disp_new_tag), 1);
    disp_is_br = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_alloc();
    bit rdy; int nt;
    do_reset();
    branch("R3", 1);
    check_eq("R3 current after branch", int'(disp_tag), 1);
    op(1'b1, 1'b0, 1'b0, 0, 1'b0, rdy, nt);
    check_eq("R2 plain accepted", int'(rdy), 1);
    check_eq("R2 current unchanged", int'(disp_tag), 1);
    branch("R4", 2);
    branch("R4", 3);
    check_eq("R3 current is youngest", int'(disp_tag), 3);
    // pool exhausted
    op(1'b1, 1'b1, 1'b0, 0, 1'b0, rdy, nt);
    check_eq("R5 branch refused when full", int'(rdy), 0);
    check_eq("R5 refused branch no change", int'(disp_tag), 3);
    disp_is_br = 1'b0; #1;
    check_eq("R5 plain ready when full", int'(disp_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_release();
    do_reset();
    branch("R6", 1); branch("R6", 2); branch("R6", 3);
    resolve(2, 1'b0);
    check_eq("R6 middle release keeps current", int'(disp_tag), 3);
    check_eq("R6 release no kill", int'(kill_valid), 0);
    branch("R12", 2);
    check_eq("R12 reused tag current", int'(disp_tag), 2);
    resolve(2, 1'b0);
    check_eq("R6 fall back by age", int'(disp_tag), 3);
  endtask

  task automatic t_mispredict();
    do_reset();
    branch("R7", 1); branch("R7", 2); branch("R7", 3);
    resolve(2, 1'b1);
    expect_kill("R7 first", 3);
    expect_kill("R7 second", 2);
    check_eq("R8 kill over", int'(kill_valid), 0);
    disp_is_br = 1'b1; #1;
    check_eq("R8 dispatch resumes", int'(disp_ready), 1);
    check_eq("R12 killed tag reused", int'(disp_new_tag), 2);
    disp_is_br = 1'b0;
    check_eq("R9 branch own tag current", int'(disp_tag), 1);
    @(negedge clk);
    branch("R12", 2);
    resolve(1, 1'b1);
    expect_kill("R7 walk a", 2);
    expect_kill("R7 walk b", 1);
    check_eq("R9 back to oldest", int'(disp_tag), 0);
  endtask

  task automatic t_ignore();
    bit rdy; int nt;
    do_reset();
    branch("R10", 1);
    resolve(3, 1'b1);
    check_eq("R10 non-live no kill", int'(kill_valid), 0);
    check_eq("R10 non-live no change", int'(disp_tag), 1);
    resolve(0, 1'b1);
    check_eq("R10 oldest no kill", int'(kill_valid), 0);
    check_eq("R10 oldest no change", int'(disp_tag), 1);
    branch("R10", 2);
    resolve(2, 1'b1);
    // a release arriving during the kill walk
    op(1'b0, 1'b0, 1'b1, 1, 1'b0, rdy, nt);
    check_eq("R10 walk ended", int'(kill_valid), 0);
    check_eq("R10 release during kill ignored", int'(disp_tag), 1);
  endtask

  task automatic t_same_cycle();
    bit rdy; int nt;
    do_reset();
    branch("R11", 1);
    op(1'b1, 1'b1, 1'b1, 1, 1'b1, rdy, nt);
    check_eq("R11 branch accepted with mispredict", int'(rdy), 1);
    check_eq("R11 tag opened with mispredict", nt, 2);
    expect_kill("R11 new tag killed first", 2);
    expect_kill("R11 then named tag", 1);
    check_eq("R11 current after walk", int'(disp_tag), 0);
    branch("R11", 1);
    branch("R11", 2);
    op(1'b1, 1'b1, 1'b1, 2, 1'b0, rdy, nt);
    check_eq("R11 tag opened with release", nt, 3);
    check_eq("R11 new tag current", int'(disp_tag), 3);
    resolve(3, 1'b0);
    check_eq("R11 released tag left order", int'(disp_tag), 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alloc();
    t_release();
    t_mispredict();
    t_ignore();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule